// File: doc/BRIEF.md
# Spike-Train FIR Threshold Filter

This block filters a stream of binary spikes with a finite impulse response kernel and returns a stream of binary spikes. It uses no multipliers. Each input sample is a single bit, so a tap either adds its coefficient into the sum or adds nothing. The sum acts as a membrane value. It is compared with a programmable threshold, and the result of that comparison is the output spike.

A sample is accepted on each clock cycle in which `in_valid` is high. The current bit and the previous `NTAPS-1` accepted bits form the window. Tap 0 is the current bit and tap k is the bit accepted k samples earlier. Coefficients are loaded at run time through a small write port. They are signed fixed-point values with `FRAC` fractional bits, so the defaults give Q2.8: the real value is code/256. The threshold uses the same format. The registered membrane value is also brought out, so the kernel can be checked at the block's edge.

Top module: `spk_fir_thresh`

## Requirements
- R1: After reset the output registers are zero (`out_valid`, `out_spike` and `out_membrane`). The tap line is also zero, so the first outputs count only the spikes received since reset.
- R2: For an accepted sample at time t, `out_membrane` equals the sum over k = 0..NTAPS-1 of coef[k]·spike[t-k]. Here spike[t] is the current `in_spike` and spike[t-k] is the bit accepted k samples earlier.
- R3: `out_spike` is 1 only when the membrane is strictly greater than the threshold. When the membrane equals the threshold, or is below it, `out_spike` is 0.
- R4: `out_valid`, `out_spike` and `out_membrane` update on the clock edge that accepts a sample, which gives a latency of exactly one cycle. `out_valid` is high for one cycle for each accepted sample and is low in every other cycle.
- R5: A cycle with `in_valid` low does not shift the tap line and does not change `out_spike` or `out_membrane`, whatever value `in_spike` has.
- R6: Coefficients and the threshold are two's complement with CW = 10 bits and 8 fractional bits. Negative coefficients subtract from the membrane.
- R7: The accumulator is CW + clog2(NTAPS) bits wide, so it does not wrap. With all coefficients at +511 and all taps set, the membrane is +3577. With all coefficients at −512 and all taps set, it is −3584.
- R8: A write with `coef_wr_en` high replaces coef[`coef_wr_idx`] from the next cycle on. A write to an index of NTAPS or above changes no coefficient.
- R9: The threshold is taken from `thr` in the same cycle as the accepted sample, so it may change from one sample to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accepts `in_spike` as a new sample |
| in_spike | input | 1 | Input spike bit |
| thr | input | CW | Signed threshold (Q2.8 by default) |
| coef_wr_en | input | 1 | Coefficient write strobe |
| coef_wr_idx | input | IDXW | Tap index of the write |
| coef_wr_data | input | CW | Signed coefficient value |
| out_valid | output | 1 | High for one cycle after each accepted sample |
| out_spike | output | 1 | Thresholded output spike |
| out_membrane | output | ACCW | Registered membrane sum |

## Verification
A single-spike impulse after reset reads the kernel back tap by tap. This separates the tap order and the zero initial state from errors in the summation. A counting sweep feeds every 7-bit pattern in sequence through a bandpass kernel that mixes signs, with a threshold that changes on each sample. This exposes wrong gating, sign extension and comparison polarity. Two more cases probe the boundaries. Idle cycles with `in_spike` toggling show that the line holds still, and an equal-versus-one-below threshold pair tests the strict comparison. Kernels set to all maximum and all minimum values, the small three-tap kernel, and a write to an out-of-range index complete the coefficient cases.

// File: rtl/spk_fir_pkg.sv
package spk_fir_pkg;

  // Accumulator width that holds NTAPS worst-case coefficients of CW bits.
  function automatic int acc_width(input int ntaps, input int cw);
    return cw + $clog2(ntaps);
  endfunction

  // Width of a tap index, never below one bit.
  function automatic int idx_width(input int ntaps);
    return (ntaps > 2) ? $clog2(ntaps) : 1;
  endfunction

endpackage

// File: rtl/spk_fir_tapline.sv
module spk_fir_tapline #(
  parameter int DEPTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             din,
  output logic [DEPTH-1:0] line
);

  logic [DEPTH:0] chain;
  assign chain[0] = din;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic stage_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        stage_q <= 1'b0;
      else if (shift_en) stage_q <= chain[g];
    end
    assign chain[g+1] = stage_q;
    assign line[g]    = stage_q;
  end

endmodule

// File: rtl/spk_fir_coef_bank.sv
module spk_fir_coef_bank #(
  parameter int NTAPS = 7,
  parameter int CW    = 10,
  parameter int IDXW  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDXW-1:0]       wr_idx,
  input  logic [CW-1:0]         wr_data,
  output logic [NTAPS*CW-1:0]   coef_flat
);

  for (genvar g = 0; g < NTAPS; g++) begin : g_entry
    logic          hit;
    logic [CW-1:0] coef_q;
    assign hit = wr_en && (wr_idx == IDXW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   coef_q <= '0;
      else if (hit) coef_q <= wr_data;
    end
    assign coef_flat[g*CW +: CW] = coef_q;
  end

endmodule

// File: rtl/spk_fir_gated_sum.sv
module spk_fir_gated_sum #(
  parameter int NTAPS = 7,
  parameter int CW    = 10,
  parameter int ACCW  = 13
) (
  input  logic [NTAPS-1:0]       window,
  input  logic [NTAPS*CW-1:0]    coef_flat,
  output logic signed [ACCW-1:0] sum
);

  // A spike bit selects its coefficient, sign-extended, or zero.
  function automatic logic signed [ACCW-1:0] gate_term(
    input logic                 hit,
    input logic signed [CW-1:0] c
  );
    logic signed [ACCW-1:0] ext;
    ext = ACCW'(c);
    return hit ? ext : '0;
  endfunction

  logic signed [ACCW-1:0] term [NTAPS];

  for (genvar g = 0; g < NTAPS; g++) begin : g_term
    assign term[g] = gate_term(window[g], coef_flat[g*CW +: CW]);
  end

  always_comb begin
    sum = '0;
    for (int k = 0; k < NTAPS; k++) sum = sum + term[k];
  end

endmodule

// File: rtl/spk_fir_thresh.sv
module spk_fir_thresh #(
  parameter int NTAPS = 7,
  parameter int CW    = 10,
  parameter int FRAC  = 8,
  localparam int ACCW = spk_fir_pkg::acc_width(NTAPS, CW),
  localparam int IDXW = spk_fir_pkg::idx_width(NTAPS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic                   in_spike,
  input  logic [CW-1:0]          thr,
  input  logic                   coef_wr_en,
  input  logic [IDXW-1:0]        coef_wr_idx,
  input  logic [CW-1:0]          coef_wr_data,
  output logic                   out_valid,
  output logic                   out_spike,
  output logic signed [ACCW-1:0] out_membrane
);

  localparam int DEPTH = NTAPS - 1;

  // The number of fractional bits fixes the meaning of the codes, not the logic.
  initial begin
    if (NTAPS < 2 || FRAC >= CW) $error("spk_fir_thresh: bad parameters");
  end

  // Fires only when the membrane is strictly above the threshold.
  function automatic logic fires(
    input logic signed [ACCW-1:0] mem,
    input logic signed [CW-1:0]   th
  );
    logic signed [ACCW-1:0] th_ext;
    th_ext = ACCW'(th);
    return mem > th_ext;
  endfunction

  logic [DEPTH-1:0]        tap_line;
  logic [NTAPS*CW-1:0]     coef_flat;
  logic [NTAPS-1:0]        window;
  logic signed [ACCW-1:0]  membrane;
  logic                    accept;
  logic                    fire_now;

  assign accept = in_valid;
  assign window = {tap_line, in_spike};

  spk_fir_tapline #(.DEPTH(DEPTH)) u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (accept),
    .din      (in_spike),
    .line     (tap_line)
  );

  spk_fir_coef_bank #(.NTAPS(NTAPS), .CW(CW), .IDXW(IDXW)) u_coef (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (coef_wr_en),
    .wr_idx    (coef_wr_idx),
    .wr_data   (coef_wr_data),
    .coef_flat (coef_flat)
  );

  spk_fir_gated_sum #(.NTAPS(NTAPS), .CW(CW), .ACCW(ACCW)) u_sum (
    .window    (window),
    .coef_flat (coef_flat),
    .sum       (membrane)
  );

  assign fire_now = fires(membrane, thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_spike    <= 1'b0;
      out_membrane <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_spike    <= fire_now;
        out_membrane <= membrane;
      end
    end
  end

endmodule

// File: rtl/spk_fir_chk.sv
module spk_fir_chk #(
  parameter int NTAPS = 7,
  parameter int CW    = 10,
  localparam int ACCW = spk_fir_pkg::acc_width(NTAPS, CW),
  localparam int IDXW = spk_fir_pkg::idx_width(NTAPS)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic [CW-1:0]          thr,
  input logic                   coef_wr_en,
  input logic [IDXW-1:0]        coef_wr_idx,
  input logic                   out_valid,
  input logic                   out_spike,
  input logic signed [ACCW-1:0] out_membrane,
  input logic [NTAPS-2:0]       tap_line,
  input logic [NTAPS*CW-1:0]    coef_flat
);

  logic signed [CW-1:0] thr_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_q <= '0;
    else        thr_q <= thr;
  end

  // R1: reset clears outputs and the line.
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !out_spike && out_membrane == '0 && tap_line == '0));

  // R4: one-cycle latency of the valid strobe.
  a_r4_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r4_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R5: idle cycles freeze the line and the outputs.
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(tap_line) && $stable(out_spike) && $stable(out_membrane)));

  // R3 / R9: output spike agrees with a strict compare against the sampled threshold.
  a_r3_strict_compare: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_spike == (out_membrane > ACCW'(thr_q))));

  // R8: a write to an index beyond the kernel changes nothing.
  a_r8_bad_index_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_wr_en && coef_wr_idx >= IDXW'(NTAPS)) |=> $stable(coef_flat));

endmodule

bind spk_fir_thresh spk_fir_chk #(.NTAPS(NTAPS), .CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .thr          (thr),
  .coef_wr_en   (coef_wr_en),
  .coef_wr_idx  (coef_wr_idx),
  .out_valid    (out_valid),
  .out_spike    (out_spike),
  .out_membrane (out_membrane),
  .tap_line     (tap_line),
  .coef_flat    (coef_flat)
);

// File: tb/spk_fir_thresh_tb.sv
`timescale 1ns/1ps
module spk_fir_thresh_tb;

  localparam int NTAPS = 7;
  localparam int CW    = 10;
  localparam int ACCW  = CW + $clog2(NTAPS);
  localparam int IDXW  = 3;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   in_valid = 1'b0;
  logic                   in_spike = 1'b0;
  logic [CW-1:0]          thr = '0;
  logic                   coef_wr_en = 1'b0;
  logic [IDXW-1:0]        coef_wr_idx = '0;
  logic [CW-1:0]          coef_wr_data = '0;
  logic                   out_valid;
  logic                   out_spike;
  logic signed [ACCW-1:0] out_membrane;

  always #2.5 clk = ~clk;

  spk_fir_thresh #(.NTAPS(NTAPS), .CW(CW), .FRAC(8)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_spike     (in_spike),
    .thr          (thr),
    .coef_wr_en   (coef_wr_en),
    .coef_wr_idx  (coef_wr_idx),
    .coef_wr_data (coef_wr_data),
    .out_valid    (out_valid),
    .out_spike    (out_spike),
    .out_membrane (out_membrane)
  );

  int checks = 0;
  int fails  = 0;
  int mcoef [NTAPS];
  int hist  [NTAPS];
  int last_mem   = 0;
  int last_spike = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  task automatic model_reset;
    for (int k = 0; k < NTAPS; k++) begin hist[k] = 0; mcoef[k] = 0; end
    last_mem = 0; last_spike = 0;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; coef_wr_en = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input int idx, input int val);
    @(negedge clk);
    in_valid = 1'b0; coef_wr_en = 1'b1;
    coef_wr_idx = IDXW'(idx); coef_wr_data = CW'(val);
    @(negedge clk);
    coef_wr_en = 1'b0;
    if (idx < NTAPS) mcoef[idx] = val;
  endtask

  // One sample (v=1) or one idle cycle (v=0), then check after the edge.
  task automatic step(input bit v, input bit s, input int th, input string req);
    int mem;
    int exp_sp;
    @(negedge clk);
    in_valid = v; in_spike = s; thr = CW'(th);
    mem = s ? mcoef[0] : 0;
    for (int k = 1; k < NTAPS; k++) if (hist[k-1] != 0) mem += mcoef[k];
    @(posedge clk);
    #1;
    if (v) begin
      for (int k = NTAPS-1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = s;
      exp_sp = (mem > th) ? 1 : 0;
      chk(out_valid == 1'b1, {req, " R4 valid"}, int'(out_valid), 1);
      chk(int'(out_membrane) == mem, {req, " R2 membrane"}, int'(out_membrane), mem);
      chk(int'(out_spike) == exp_sp, {req, " R3 spike"}, int'(out_spike), exp_sp);
      last_mem = mem; last_spike = exp_sp;
    end else begin
      chk(out_valid == 1'b0, {req, " R4 idle valid"}, int'(out_valid), 0);
      chk(int'(out_membrane) == last_mem, {req, " R5 hold mem"}, int'(out_membrane), last_mem);
      chk(int'(out_spike) == last_spike, {req, " R5 hold spike"}, int'(out_spike), last_spike);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic load(input int c0, input int c1, input int c2, input int c3,
                      input int c4, input int c5, input int c6);
    wr(0, c0); wr(1, c1); wr(2, c2); wr(3, c3); wr(4, c4); wr(5, c5); wr(6, c6);
  endtask

  initial begin
    do_reset();
    #1;
    // R1: reset state
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(out_spike == 1'b0, "R1 out_spike", int'(out_spike), 0);
    chk(out_membrane == '0, "R1 out_membrane", int'(out_membrane), 0);

    // R6: bandpass kernel in Q2.8, threshold 0.3 = 77
    load(51, 128, 128, 51, -26, -77, -26);
    // R1/R2: impulse reads the kernel back tap by tap
    step(1, 1, 77, "impulse");
    for (int n = 0; n < NTAPS + 1; n++) step(1, 0, 77, "impulse tail");

    // R2/R3/R9: every 7-bit pattern in sequence, threshold varying per sample
    for (int n = 0; n < 128; n++)
      for (int b = 0; b < NTAPS; b++)
        step(1, n[b], ((n * 37 + b * 11) % 300) - 150, "sweep R9");

    // R5: idle cycles with in_spike toggling
    step(1, 1, 0, "pre-idle");
    for (int n = 0; n < 6; n++) step(0, n[0], -100, "idle R5");
    step(1, 0, 0, "post-idle R5");

    // R3: equality with threshold gives no spike; one below gives a spike
    do_reset();
    load(128, 0, 0, 0, 0, 0, 0);
    step(1, 1, 128, "equal R3");
    step(1, 1, 127, "below R3");

    // R7: extremes of the accumulator
    load(511, 511, 511, 511, 511, 511, 511);
    for (int n = 0; n < NTAPS; n++) step(1, 1, 511, "max R7");
    chk(int'(out_membrane) == 3577, "R7 max sum", int'(out_membrane), 3577);
    load(-512, -512, -512, -512, -512, -512, -512);
    step(1, 1, -512, "min R7");
    chk(int'(out_membrane) == -3584, "R7 min sum", int'(out_membrane), -3584);

    // R8: out-of-range write changes no coefficient
    do_reset();
    load(128, 77, 51, 0, 0, 0, 0);
    wr(7, 300);
    step(1, 1, 128, "3-tap R8");
    step(1, 1, 128, "3-tap R8");
    step(1, 1, 128, "3-tap R8");
    chk(int'(out_membrane) == 256, "R8 3-tap full", int'(out_membrane), 256);
    step(1, 0, 128, "3-tap R2");
    step(1, 1, 128, "3-tap R2");
    // R8: in-range rewrite takes effect
    wr(1, -100);
    step(1, 1, 0, "rewrite R8");

    summary();
    $finish;
  end

endmodule